// File: doc/BRIEF.md
# Memory Request Latency Profiler

This block watches a stream of completed memory requests, one per clock at most, and keeps bucketed latency histograms in hardware. Each completion carries its total latency, a request type, a responder class, a hit/miss flag and five timestamps that mark the moments the request was issued, first sent out, forwarded, first answered and finished. The total latency is binned into an overall histogram and into histograms split by hit versus miss, by request type and by responder class.

For misses answered by a known responder, the block also breaks the latency into four back-to-back phases: issue to initial send, initial send to forward, forward to first answer, and first answer to completion. It bins each phase only after it has confirmed that the five timestamps never run backwards. When they do run backwards, it increments a per-responder count of incomplete breakdowns instead. Every histogram has `NBKT` buckets of width `2**BSH`. A value past the last bucket lands in the last bucket. Every counter saturates rather than wraps. All counts can be read through one indexed, combinational read port, and the reset clears them all.

Top module: `lat_profiler`

## Requirements
- R1: While and after the asynchronous active-low reset, every counter reads zero.
- R2: A cycle with `done_valid_i` high adds one to bucket `b(lat_i)` of the overall histogram (id 0). It also adds one to that bucket of the type histogram `3 + type_i`. Here `b(v) = min(v >> BSH, NBKT-1)`.
- R3: A hit (`miss_i` = 0) also counts in histogram 1 and in hit-type histogram `3 + NT + type_i`. A miss also counts in histogram 2 and in miss-type histogram `3 + 2*NT + type_i`.
- R4: A responder class below `NR` counts in histogram `3 + 3*NT + resp_i` (hit) or `3 + 3*NT + NR + resp_i` (miss). Any value of `NR` or above means "no responder", and then no class, phase or incomplete counter changes.
- R5: Take a miss with a valid class c whose timestamps satisfy issue ≤ initial ≤ forward ≤ first ≤ completion, where equality counts as ordered. For such a miss, phase p (0..3, in the order the phases run) adds one to bucket `b(interval p)` of histogram `PH + 4*c + p`, with `PH = 3 + 3*NT + 2*NR`.
- R6: Take a miss with a valid class c whose timestamps break that order anywhere. For such a miss, incomplete counter c (read index `NH*NBKT + c`, with `NH = PH + 4*NR`) adds one, and no phase histogram changes.
- R7: A hit never changes a phase histogram or an incomplete counter, whatever its timestamps.
- R8: A latency or interval of `(NBKT-1) << BSH` or more counts in the last bucket.
- R9: Every counter stops at `2**CNTW - 1` and never wraps to zero.
- R10: `rd_data_o` shows, in the same cycle, histogram h bucket k at index `h*NBKT + k` and incomplete counter c at `NH*NBKT + c`. Any index at or above `NH*NBKT + NR` reads zero.
- R11: Asserting the reset in the middle of operation clears every counter that had been counted up.
- R12: While `done_valid_i` is low, no counter changes, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears all counters |
| done_valid_i | input | 1 | A completion is presented this cycle |
| lat_i | input | LW | Total latency of the completion |
| type_i | input | TW | Request type, 0..NT-1 |
| resp_i | input | CW | Responder class, 0..NR-1 valid, NR and above none |
| miss_i | input | 1 | 1 = missed, 0 = hit |
| ts_issue_i | input | TSW | Issue timestamp |
| ts_init_i | input | TSW | Initial send timestamp |
| ts_fwd_i | input | TSW | Forward timestamp |
| ts_first_i | input | TSW | First answer timestamp |
| ts_cmpl_i | input | TSW | Completion timestamp |
| rd_idx_i | input | AW | Counter index to read |
| rd_data_o | output | CNTW | Counter value at `rd_idx_i` |

## Verification
The bench builds the block with two request types, two responder classes, ten buckets of width two and 4-bit counters, which gives 212 counters. That is small enough to read back every counter after each stimulus group and to sweep every index past the end of the map. The 4-bit counters reach saturation after fifteen completions. Eight-bit latencies and timestamps make the last-bucket clamp, equal timestamps and each of the four ordering violations cheap to produce.

// File: rtl/lat_prof_pkg.sv
package lat_prof_pkg;
  // phase intervals of a miss, in the order they elapse
  typedef enum int unsigned {
    PH_ISSUE_TO_INIT = 0,
    PH_INIT_TO_FWD   = 1,
    PH_FWD_TO_FIRST  = 2,
    PH_FIRST_TO_DONE = 3
  } phase_e;

  localparam int unsigned NUM_PHASES = 4;
  localparam int unsigned NUM_STAMPS = NUM_PHASES + 1;
endpackage

// File: rtl/lat_bin.sv
module lat_bin #(
  parameter int unsigned VW   = 16,
  parameter int unsigned BSH  = 2,
  parameter int unsigned NBKT = 10,
  localparam int unsigned BW  = $clog2(NBKT)
) (
  input  logic [VW-1:0] val_i,
  output logic [BW-1:0] bkt_o
);
  logic [VW-1:0] scaled;

  always_comb begin
    scaled = val_i >> BSH;
    if (scaled >= VW'(NBKT - 1)) bkt_o = BW'(NBKT - 1);
    else                         bkt_o = scaled[BW-1:0];
  end
endmodule

// File: rtl/lat_phase.sv
module lat_phase
  import lat_prof_pkg::*;
#(
  parameter int unsigned TSW = 16
) (
  input  logic [TSW-1:0]            ts_issue_i,
  input  logic [TSW-1:0]            ts_init_i,
  input  logic [TSW-1:0]            ts_fwd_i,
  input  logic [TSW-1:0]            ts_first_i,
  input  logic [TSW-1:0]            ts_cmpl_i,
  output logic                      ordered_o,
  output logic [NUM_PHASES*TSW-1:0] iv_o
);
  logic [TSW-1:0] stamp [NUM_STAMPS];

  assign stamp[0] = ts_issue_i;
  assign stamp[1] = ts_init_i;
  assign stamp[2] = ts_fwd_i;
  assign stamp[3] = ts_first_i;
  assign stamp[4] = ts_cmpl_i;

  for (genvar p = 0; p < NUM_PHASES; p++) begin : g_iv
    assign iv_o[p*TSW +: TSW] = stamp[p+1] - stamp[p];
  end

  always_comb begin
    ordered_o = 1'b1;
    for (int p = 0; p < NUM_PHASES; p++) begin
      if (stamp[p] > stamp[p+1]) ordered_o = 1'b0;
    end
  end
endmodule

// File: rtl/lat_hist.sv
module lat_hist #(
  parameter int unsigned NBKT = 10,
  parameter int unsigned CNTW = 16,
  localparam int unsigned BW  = $clog2(NBKT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 inc_i,
  input  logic [BW-1:0]        bkt_i,
  output logic [NBKT*CNTW-1:0] cnt_o
);
  logic [CNTW-1:0] cnt_q [NBKT];
  logic [CNTW-1:0] cnt_d [NBKT];
  logic [NBKT-1:0] cnt_en;

  for (genvar b = 0; b < NBKT; b++) begin : g_bkt
    always_comb begin
      cnt_en[b] = inc_i && (bkt_i == BW'(b)) && (cnt_q[b] != '1);
      cnt_d[b]  = cnt_q[b] + CNTW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt_q[b] <= '0;
      else if (cnt_en[b]) cnt_q[b] <= cnt_d[b];
    end

    assign cnt_o[b*CNTW +: CNTW] = cnt_q[b];
  end
endmodule

// File: rtl/lat_profiler.sv
module lat_profiler
  import lat_prof_pkg::*;
#(
  parameter int unsigned NT   = 4,
  parameter int unsigned NR   = 3,
  parameter int unsigned NBKT = 10,
  parameter int unsigned BSH  = 2,
  parameter int unsigned CNTW = 16,
  parameter int unsigned LW   = 16,
  parameter int unsigned TSW  = 16,
  localparam int unsigned TW     = (NT > 1) ? $clog2(NT) : 1,
  localparam int unsigned CW     = $clog2(NR + 1),
  localparam int unsigned H_TYP  = 3,
  localparam int unsigned H_HTYP = H_TYP + NT,
  localparam int unsigned H_MTYP = H_HTYP + NT,
  localparam int unsigned H_HCLS = H_MTYP + NT,
  localparam int unsigned H_MCLS = H_HCLS + NR,
  localparam int unsigned H_PH   = H_MCLS + NR,
  localparam int unsigned NH     = H_PH + NUM_PHASES * NR,
  localparam int unsigned NHC    = NH * NBKT,
  localparam int unsigned NCNT   = NHC + NR,
  localparam int unsigned AW     = $clog2(NCNT) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            done_valid_i,
  input  logic [LW-1:0]   lat_i,
  input  logic [TW-1:0]   type_i,
  input  logic [CW-1:0]   resp_i,
  input  logic            miss_i,
  input  logic [TSW-1:0]  ts_issue_i,
  input  logic [TSW-1:0]  ts_init_i,
  input  logic [TSW-1:0]  ts_fwd_i,
  input  logic [TSW-1:0]  ts_first_i,
  input  logic [TSW-1:0]  ts_cmpl_i,
  input  logic [AW-1:0]   rd_idx_i,
  output logic [CNTW-1:0] rd_data_o
);
  localparam int unsigned BW    = $clog2(NBKT);
  localparam int unsigned H_ALL = 0;
  localparam int unsigned H_HIT = 1;
  localparam int unsigned H_MIS = 2;

  logic [NCNT*CNTW-1:0] cnt_flat;

  // ---------------- binning of the total latency and the phases ----------------
  logic [BW-1:0]             lat_bkt;
  logic                      ordered;
  logic [NUM_PHASES*TSW-1:0] iv;
  logic [BW-1:0]             iv_bkt [NUM_PHASES];

  lat_bin #(.VW(LW), .BSH(BSH), .NBKT(NBKT)) u_lat_bin (
    .val_i (lat_i),
    .bkt_o (lat_bkt)
  );

  lat_phase #(.TSW(TSW)) u_phase (
    .ts_issue_i (ts_issue_i),
    .ts_init_i  (ts_init_i),
    .ts_fwd_i   (ts_fwd_i),
    .ts_first_i (ts_first_i),
    .ts_cmpl_i  (ts_cmpl_i),
    .ordered_o  (ordered),
    .iv_o       (iv)
  );

  for (genvar p = 0; p < NUM_PHASES; p++) begin : g_iv_bin
    lat_bin #(.VW(TSW), .BSH(BSH), .NBKT(NBKT)) u_iv_bin (
      .val_i (iv[p*TSW +: TSW]),
      .bkt_o (iv_bkt[p])
    );
  end

  // ---------------- increment steering ----------------
  logic          cls_ok;
  logic          typ_ok;
  logic [NH-1:0] hist_inc;
  logic [BW-1:0] hist_bkt [NH];
  logic [NR-1:0] incmp_inc;

  always_comb begin
    cls_ok = (int'(resp_i) < NR);
    typ_ok = (int'(type_i) < NT);
    for (int h = 0; h < NH; h++) hist_bkt[h] = lat_bkt;
    for (int c = 0; c < NR; c++) begin
      for (int p = 0; p < NUM_PHASES; p++) begin
        hist_bkt[H_PH + c*NUM_PHASES + p] = iv_bkt[p];
      end
    end

    hist_inc  = '0;
    incmp_inc = '0;
    if (done_valid_i) begin
      hist_inc[H_ALL] = 1'b1;
      if (miss_i) hist_inc[H_MIS] = 1'b1;
      else        hist_inc[H_HIT] = 1'b1;
      if (typ_ok) begin
        hist_inc[H_TYP + int'(type_i)] = 1'b1;
        if (miss_i) hist_inc[H_MTYP + int'(type_i)] = 1'b1;
        else        hist_inc[H_HTYP + int'(type_i)] = 1'b1;
      end
      if (cls_ok) begin
        if (miss_i) begin
          hist_inc[H_MCLS + int'(resp_i)] = 1'b1;
          if (ordered) begin
            for (int p = 0; p < NUM_PHASES; p++) begin
              hist_inc[H_PH + int'(resp_i)*NUM_PHASES + p] = 1'b1;
            end
          end else begin
            incmp_inc[int'(resp_i)] = 1'b1;
          end
        end else begin
          hist_inc[H_HCLS + int'(resp_i)] = 1'b1;
        end
      end
    end
  end

  // ---------------- histogram banks ----------------
  for (genvar h = 0; h < NH; h++) begin : g_hist
    lat_hist #(.NBKT(NBKT), .CNTW(CNTW)) u_hist (
      .clk   (clk),
      .rst_n (rst_n),
      .inc_i (hist_inc[h]),
      .bkt_i (hist_bkt[h]),
      .cnt_o (cnt_flat[h*NBKT*CNTW +: NBKT*CNTW])
    );
  end

  // ---------------- incomplete breakdown counters ----------------
  for (genvar c = 0; c < NR; c++) begin : g_incmp
    logic [CNTW-1:0] inc_q;
    logic [CNTW-1:0] inc_d;
    logic            inc_en;

    always_comb begin
      inc_en = incmp_inc[c] && (inc_q != '1);
      inc_d  = inc_q + CNTW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      inc_q <= '0;
      else if (inc_en) inc_q <= inc_d;
    end

    assign cnt_flat[(NHC + c)*CNTW +: CNTW] = inc_q;
  end

  // ---------------- read port ----------------
  always_comb begin
    rd_data_o = '0;
    if (int'(rd_idx_i) < NCNT) rd_data_o = cnt_flat[int'(rd_idx_i)*CNTW +: CNTW];
  end
endmodule

// File: rtl/lat_profiler_chk.sv
module lat_profiler_chk #(
  parameter int unsigned NCNT   = 4,
  parameter int unsigned CNTW   = 16,
  parameter int unsigned NR     = 3,
  parameter int unsigned CW     = 2,
  parameter int unsigned AW     = 3,
  parameter int unsigned CLS_LO = 0,
  parameter int unsigned PH_LO  = 0
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 done_valid_i,
  input logic                 miss_i,
  input logic [CW-1:0]        resp_i,
  input logic [AW-1:0]        rd_idx_i,
  input logic [CNTW-1:0]      rd_data_o,
  input logic [NCNT*CNTW-1:0] cnt_flat
);
  // R12: an idle cycle leaves every counter alone
  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !done_valid_i |=> $stable(cnt_flat));

  // R4: no responder means nothing at or above the class region moves
  assert_cls_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid_i && (int'(resp_i) >= NR)) |=> $stable(cnt_flat[NCNT*CNTW-1:CLS_LO]));

  // R7: hits leave phase histograms and incomplete counters untouched
  assert_hit_no_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid_i && !miss_i) |=> $stable(cnt_flat[NCNT*CNTW-1:PH_LO]));

  // R10: indices past the map read zero
  assert_rd_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_idx_i) >= NCNT) |-> (rd_data_o == '0));

  // R9: each counter holds or steps by one, so it never wraps
  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_flat[i*CNTW +: CNTW] == $past(cnt_flat[i*CNTW +: CNTW])) ||
      (cnt_flat[i*CNTW +: CNTW] == $past(cnt_flat[i*CNTW +: CNTW]) + CNTW'(1)));
  end
endmodule

bind lat_profiler lat_profiler_chk #(
  .NCNT   (NCNT),
  .CNTW   (CNTW),
  .NR     (NR),
  .CW     (CW),
  .AW     (AW),
  .CLS_LO (H_HCLS * NBKT * CNTW),
  .PH_LO  (H_PH * NBKT * CNTW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .done_valid_i (done_valid_i),
  .miss_i       (miss_i),
  .resp_i       (resp_i),
  .rd_idx_i     (rd_idx_i),
  .rd_data_o    (rd_data_o),
  .cnt_flat     (cnt_flat)
);

// File: tb/lat_profiler_bench.sv
`timescale 1ns/1ps
module lat_profiler_bench;
  localparam int NT = 2, NR = 2, NBKT = 10, BSH = 1, CNTW = 4, LW = 8, TSW = 8;
  localparam int H_TYP = 3, H_HTYP = 5, H_MTYP = 7, H_HCLS = 9, H_MCLS = 11, H_PH = 13;
  localparam int NH = 21, NCNT = NH * NBKT + NR, AW = 9, MAXC = 15;

  logic clk = 1'b0;
  logic rst_n;
  logic done_valid;
  logic [LW-1:0] lat;
  logic [0:0] typ;
  logic [1:0] resp;
  logic miss;
  logic [TSW-1:0] t0, t1, t2, t3, t4;
  logic [AW-1:0] rd_idx;
  logic [CNTW-1:0] rd_data;

  int exp_cnt [NCNT];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  lat_profiler #(.NT(NT), .NR(NR), .NBKT(NBKT), .BSH(BSH), .CNTW(CNTW), .LW(LW), .TSW(TSW))
  u_lat_profiler (
    .clk(clk), .rst_n(rst_n), .done_valid_i(done_valid), .lat_i(lat), .type_i(typ),
    .resp_i(resp), .miss_i(miss), .ts_issue_i(t0), .ts_init_i(t1), .ts_fwd_i(t2),
    .ts_first_i(t3), .ts_cmpl_i(t4), .rd_idx_i(rd_idx), .rd_data_o(rd_data)
  );

  function automatic int bkt(int v);
    return ((v >> BSH) > NBKT - 1) ? NBKT - 1 : (v >> BSH);
  endfunction

  function automatic void bump(int idx);
    if (exp_cnt[idx] < MAXC) exp_cnt[idx]++;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < NCNT; i++) exp_cnt[i] = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    model_clear();
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send(int l, int ty, int c, bit m, int a0, int a1, int a2, int a3, int a4);
    int bl;
    bit ord;
    int ts [5];
    @(negedge clk);
    lat = LW'(l); typ = 1'(ty); resp = 2'(c); miss = m;
    t0 = TSW'(a0); t1 = TSW'(a1); t2 = TSW'(a2); t3 = TSW'(a3); t4 = TSW'(a4);
    done_valid = 1'b1;
    ts[0] = a0; ts[1] = a1; ts[2] = a2; ts[3] = a3; ts[4] = a4;
    bl = bkt(l);
    bump(bl);                                    // R2 overall
    bump((m ? 2 : 1) * NBKT + bl);               // R3
    bump((H_TYP + ty) * NBKT + bl);              // R2 per type
    bump(((m ? H_MTYP : H_HTYP) + ty) * NBKT + bl);
    if (c < NR) begin                            // R4
      bump(((m ? H_MCLS : H_HCLS) + c) * NBKT + bl);
      if (m) begin
        ord = 1;
        for (int p = 0; p < 4; p++) if (ts[p] > ts[p+1]) ord = 0;
        if (ord) for (int p = 0; p < 4; p++) bump((H_PH + c*4 + p) * NBKT + bkt(ts[p+1] - ts[p]));  // R5
        else bump(NH * NBKT + c);                // R6
      end
    end
    @(negedge clk);
    done_valid = 1'b0;
  endtask

  task automatic compare_all(string tag);
    for (int i = 0; i < NCNT; i++) begin
      @(negedge clk);
      rd_idx = AW'(i);
      #1;
      checks++;
      if (rd_data !== CNTW'(exp_cnt[i])) begin
        errors++;
        $display("FAIL %s index %0d: actual %0d expected %0d", tag, i, rd_data, exp_cnt[i]);
      end
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; done_valid = 1'b0; lat = '0; typ = '0; resp = '0; miss = 1'b0;
    t0 = '0; t1 = '0; t2 = '0; t3 = '0; t4 = '0; rd_idx = '0;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    compare_all("R1 reset");

    // R2 R3 R8: latency sweep through every bucket and past the last, no responder
    for (int l = 0; l < 26; l++) send(l, l % 2, 2 + (l % 2), (l / 3) % 2, 0, 1, 2, 3, 4);
    send(255, 1, 3, 1'b1, 9, 1, 2, 3, 4);
    compare_all("R2 R3 R8 latency sweep");

    // R11: reset in the middle of operation
    do_reset();
    compare_all("R11 mid-run reset");

    // R4 R5: valid classes, ordered stamps, varied and equal intervals
    for (int c = 0; c < NR; c++) begin
      for (int k = 0; k < 6; k++) begin
        send(3*k + c, k % 2, c, 1'b1, 10, 10 + k, 10 + 3*k, 10 + 7*k, 40 + 9*k);
        send(2*k, c, c, 1'b0, 10, 10 + k, 10 + 3*k, 10 + 7*k, 40 + 9*k);
      end
      send(7, 0, c, 1'b1, 50, 50, 50, 50, 50);
    end
    compare_all("R4 R5 ordered breakdown");

    // R6: each adjacent pair out of order, per class
    do_reset();
    for (int c = 0; c < NR; c++) begin
      send(5, 0, c, 1'b1, 20, 19, 30, 40, 50);
      send(5, 1, c, 1'b1, 20, 25, 24, 40, 50);
      send(5, 0, c, 1'b1, 20, 25, 30, 29, 50);
      send(5, 1, c, 1'b1, 20, 25, 30, 40, 39);
    end
    send(6, 0, 0, 1'b1, 1, 2, 3, 4, 5);
    compare_all("R6 incomplete count");

    // R7: hits with disordered and ordered stamps
    do_reset();
    for (int c = 0; c < NR; c++) begin
      send(4, 0, c, 1'b0, 50, 1, 60, 2, 3);
      send(9, 1, c, 1'b0, 1, 2, 3, 4, 200);
    end
    compare_all("R7 hit no breakdown");

    // R12: idle cycles with busy inputs
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      lat = LW'(k * 17); typ = 1'(k); resp = 2'(k); miss = k[0];
      t0 = TSW'(k); t1 = TSW'(k + 3); t2 = TSW'(k * 5); t3 = '1; t4 = '0;
    end
    compare_all("R12 idle ignored");

    // R9: saturation at 15
    do_reset();
    for (int k = 0; k < 20; k++) send(5, 0, 0, 1'b1, 0, 0, 0, 0, 0);
    for (int k = 0; k < 18; k++) send(5, 1, 1, 1'b1, 5, 4, 6, 7, 8);
    compare_all("R9 saturation");

    // R10: indices beyond the map read zero
    for (int i = NCNT; i < (1 << AW); i++) begin
      @(negedge clk);
      rd_idx = AW'(i);
      #1;
      checks++;
      if (rd_data !== '0) begin
        errors++;
        $display("FAIL R10 index %0d: actual %0d expected 0", i, rd_data);
      end
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule